// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank State Tracking

This block sits at the device side of a four-bank synchronous DRAM. It registers the chip select, the three command strobes, the bank address, the address bus and the clock enable on every rising clock edge. In the following cycle it presents exactly one decoded command strobe, together with the bank, the column and the auto-precharge bit of that command.

Each bank has its own idle/active state, open row and pending auto-precharge. Commands that do not fit the current bank state are flagged as illegal and change nothing. The block also follows the length of the current burst, the mode word and the power state selected by the clock enable. Other device logic uses these outputs to decide what the array and the data path do.

Top module: `sdram_cmd_front`

## Requirements
- R1: Inputs are sampled only on the rising clock edge. The command sampled at an edge is shown during the cycle after that edge. Exactly one of the nine strobes cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref, cmd_bst, cmd_mrs is high in every cycle.
- R2: When cs_n is sampled high, the command is shown as cmd_nop and has no effect on any state.
- R3: With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 111 no-op, 011 ACTIVE, 101 READ, 100 WRITE, 110 burst stop, 010 PRECHARGE, 001 auto refresh, 000 mode register set. A PRECHARGE with addr[10] high is shown as cmd_prea, otherwise as cmd_pre. cmd_bank shows ba, cmd_col shows addr[7:0] and cmd_autopre shows addr[10].
- R4: An ACTIVE to an idle bank sets that bank's bank_active bit at the next edge and stores addr[11:0] as its open row. Bank b's row is at open_rows[12*b+11:12*b].
- R5: illegal_cmd is high in the cycle a command is shown, and the command changes no state, in these cases: a READ or WRITE to an idle bank or to a bank with an auto precharge pending; an ACTIVE to an active bank; an auto refresh or mode register set while any bank is active.
- R6: PRECHARGE closes the addressed bank and precharge-all closes every bank at the next edge. A closed bank's row reads 0 and its pending auto precharge is cancelled. A PRECHARGE to an idle bank has no effect.
- R7: A legal READ or WRITE with addr[10] high sets the bank's ap_pending bit at the next edge. The bank turns idle, with row 0, BL edges after that edge.
- R8: A legal mode register set stores addr into mode_word at the next edge. mode_word[2:0] selects the burst length BL: 0→1, 1→2, 2→4, 3→8, 7→256 (full page), any other code→1.
- R9: After the edge that applies a legal READ or WRITE, burst_busy is high for BL cycles. It drops at the next edge after a burst stop, a precharge-all, or a PRECHARGE to the bank of the burst. A new READ or WRITE restarts the count.
- R10: pwr_state encodes 0 as running, 1 as precharge power-down, 2 as self refresh and 3 as active power-down. At the edge after cke is sampled low while running, the state becomes 2 if the shown command is a legal auto refresh, else 3 if any bank is active, else 1. The state is held while cke stays low and returns to 0 at the edge after cke is sampled high.
- R11: While pwr_state is not 0, every command is shown as cmd_nop and has no effect. Pending auto precharges and burst counts keep running.
- R12: A synchronous active-low reset leaves these values after the edge: all banks idle, every row 0, no auto precharge pending, burst_busy low, mode_word 0, pwr_state 0, cmd_nop high and illegal_cmd low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, part of the command code |
| cas_n | input | 1 | Column strobe, part of the command code |
| we_n | input | 1 | Write strobe, part of the command code |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row / column / mode address; bit 10 selects auto precharge or all banks |
| cmd_nop | output | 1 | No-operation (including masked commands) |
| cmd_act | output | 1 | ACTIVE decoded |
| cmd_rd | output | 1 | READ decoded |
| cmd_wr | output | 1 | WRITE decoded |
| cmd_pre | output | 1 | Single-bank PRECHARGE decoded |
| cmd_prea | output | 1 | Precharge-all decoded |
| cmd_ref | output | 1 | Auto refresh decoded |
| cmd_bst | output | 1 | Burst stop decoded |
| cmd_mrs | output | 1 | Mode register set decoded |
| cmd_bank | output | 2 | Bank of the shown command |
| cmd_col | output | 8 | Column of the shown command |
| cmd_autopre | output | 1 | Auto-precharge bit of the shown command |
| illegal_cmd | output | 1 | Shown command conflicts with bank state |
| bank_active | output | 4 | One bit per bank, high while a row is open |
| ap_pending | output | 4 | One bit per bank, auto precharge pending |
| open_rows | output | 48 | Open row of each bank, 12 bits per bank |
| burst_busy | output | 1 | A burst is in progress |
| pwr_state | output | 2 | Power state (0 run, 1 precharge power-down, 2 self refresh, 3 active power-down) |
| mode_word | output | 12 | Last legal mode register value |

## Verification
The hardest situation to reach is a timing coincidence. An auto-precharge countdown can expire at the same edge as another command to that bank, or the clock enable can drop in exactly the cycle that carries an auto refresh while every bank is idle. The directed part of the stimulus reaches these by counting edges after a READ with auto precharge. It also drops cke together with the refresh code, and drops it again with a row open. A long pseudo-random phase then mixes commands, banks, deselects and clock-enable pulses. A behavioural model in the bench follows every cycle of all of this.

// File: rtl/sdram_cmd_pkg.sv
// Shared types for the SDRAM command front end.
// Assumes: burst length codes follow the mode-word mapping in the brief.
package sdram_cmd_pkg;

    typedef enum logic [1:0] {
        PWR_RUN    = 2'd0,
        PWR_PRE_PD = 2'd1,
        PWR_SELF   = 2'd2,
        PWR_ACT_PD = 2'd3
    } pwr_e;

    typedef struct packed {
        logic nop;
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic prea;
        logic refr;
        logic bst;
        logic mrs;
    } cmd_strobe_t;

    // Burst length in beats for a mode-word length code
    function automatic int unsigned burst_beats(input logic [2:0] code,
                                                input int unsigned col_w);
        case (code)
            3'd0:    burst_beats = 1;
            3'd1:    burst_beats = 2;
            3'd2:    burst_beats = 4;
            3'd3:    burst_beats = 8;
            3'd7:    burst_beats = 1 << col_w;
            default: burst_beats = 1;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_capture.sv
// Input register stage and command decoder.
// Registers every pin on the rising edge, then decodes the held code into a
// one-hot strobe set. Masks to no-op while deselected or outside run mode.
// Assumes: ROW_W > AP_BIT.
module sdram_cmd_capture
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] addr,
    input  logic             run,
    output cmd_strobe_t      strobe,
    output logic [BA_W-1:0]  ba_q,
    output logic [ROW_W-1:0] addr_q,
    output logic             cke_q
);

    logic cs_q, ras_q, cas_q, we_q;

    // Sample all pins on the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            ras_q  <= 1'b1;
            cas_q  <= 1'b1;
            we_q   <= 1'b1;
            ba_q   <= '0;
            addr_q <= '0;
            cke_q  <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            ras_q  <= ras_n;
            cas_q  <= cas_n;
            we_q   <= we_n;
            ba_q   <= ba;
            addr_q <= addr;
            cke_q  <= cke;
        end
    end

    // Decode the held command code into one strobe
    always_comb begin
        strobe = '0;
        if (!run || cs_q) begin
            strobe.nop = 1'b1;
        end else begin
            unique case ({ras_q, cas_q, we_q})
                3'b111: strobe.nop  = 1'b1;
                3'b011: strobe.act  = 1'b1;
                3'b101: strobe.rd   = 1'b1;
                3'b100: strobe.wr   = 1'b1;
                3'b110: strobe.bst  = 1'b1;
                3'b010: begin
                    strobe.prea = addr_q[AP_BIT];
                    strobe.pre  = !addr_q[AP_BIT];
                end
                3'b001: strobe.refr = 1'b1;
                3'b000: strobe.mrs  = 1'b1;
                default: strobe.nop = 1'b1;
            endcase
        end
    end

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobe) == 1);

endmodule

// File: rtl/sdram_bank_unit.sv
// State of one bank: active flag, open row, auto-precharge countdown.
// Assumes the caller only asserts legal, mutually exclusive requests.
module sdram_bank_unit #(
    parameter int ROW_W = 12,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic [ROW_W-1:0] row_in,
    input  logic             do_rw_ap,
    input  logic [CNT_W-1:0] beats,
    input  logic             do_close,
    output logic             active,
    output logic [ROW_W-1:0] row,
    output logic             ap_pend
);

    logic [CNT_W-1:0] cnt;

    // Open, close and auto-precharge countdown for this bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            row     <= '0;
            ap_pend <= 1'b0;
            cnt     <= '0;
        end else if (do_close) begin
            active  <= 1'b0;
            row     <= '0;
            ap_pend <= 1'b0;
            cnt     <= '0;
        end else if (do_act) begin
            active <= 1'b1;
            row    <= row_in;
        end else if (do_rw_ap) begin
            ap_pend <= 1'b1;
            cnt     <= beats;
        end else if (ap_pend && cnt == CNT_W'(1)) begin
            active  <= 1'b0;
            row     <= '0;
            ap_pend <= 1'b0;
            cnt     <= '0;
        end else if (ap_pend) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // R7
    ap_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_pend |-> active);

    // R4
    act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |=> (active && row == $past(row_in)));

endmodule

// File: rtl/sdram_burst_track.sv
// Tracks the burst in progress and its owning bank.
// Assumes beats >= 1 whenever start is asserted.
module sdram_burst_track #(
    parameter int BA_W  = 2,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BA_W-1:0]  start_bank,
    input  logic [CNT_W-1:0] beats,
    input  logic             stop,
    input  logic             pre_one,
    input  logic [BA_W-1:0]  pre_bank,
    input  logic             pre_all,
    output logic             busy
);

    logic [CNT_W-1:0] cnt;
    logic [BA_W-1:0]  owner;
    logic             kill;

    // A burst ends on stop or a precharge that hits its bank
    assign kill = stop || pre_all || (pre_one && pre_bank == owner);

    // Burst beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            owner <= '0;
        end else if (kill) begin
            cnt <= '0;
        end else if (start) begin
            cnt   <= beats;
            owner <= start_bank;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);

    // R9
    stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy);

    // R9
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/sdram_power_ctl.sv
// Power state chosen from the sampled clock enable.
// The state is picked on entry and held until clock enable returns high.
module sdram_power_ctl
    import sdram_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke_q,
    input  logic sr_req,
    input  logic any_active,
    output pwr_e state
);

    // Low-power entry and exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PWR_RUN;
        end else if (cke_q) begin
            state <= PWR_RUN;
        end else if (state == PWR_RUN) begin
            if (sr_req)          state <= PWR_SELF;
            else if (any_active) state <= PWR_ACT_PD;
            else                 state <= PWR_PRE_PD;
        end
    end

    // R10
    act_pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PWR_ACT_PD && $past(state) == PWR_RUN) |-> $past(any_active));

    // R10
    self_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PWR_SELF && $past(state) == PWR_RUN) |-> $past(sr_req));

endmodule

// File: rtl/sdram_cmd_front.sv
// SDRAM device-side command front end.
// Decodes registered pin commands, checks them against per-bank state,
// updates banks, burst tracking, mode word and power state.
// Assumes NUM_BANKS is a power of two and ROW_W > AP_BIT >= COL_W.
module sdram_cmd_front
    import sdram_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int CNT_W    = COL_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic                       cmd_nop,
    output logic                       cmd_act,
    output logic                       cmd_rd,
    output logic                       cmd_wr,
    output logic                       cmd_pre,
    output logic                       cmd_prea,
    output logic                       cmd_ref,
    output logic                       cmd_bst,
    output logic                       cmd_mrs,
    output logic [BA_W-1:0]            cmd_bank,
    output logic [COL_W-1:0]           cmd_col,
    output logic                       cmd_autopre,
    output logic                       illegal_cmd,
    output logic [NUM_BANKS-1:0]       bank_active,
    output logic [NUM_BANKS-1:0]       ap_pending,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic                       burst_busy,
    output logic [1:0]                 pwr_state,
    output logic [ROW_W-1:0]           mode_word
);

    cmd_strobe_t          st;
    logic [BA_W-1:0]      ba_q;
    logic [ROW_W-1:0]     addr_q;
    logic                 cke_q;
    pwr_e                 pwr;
    logic                 run;
    logic [NUM_BANKS-1:0] sel;
    logic                 tgt_active, tgt_ap, any_active;
    logic                 is_rw, is_hk;
    logic                 act_ok, rw_ok, hk_ok;
    logic [CNT_W-1:0]     beats_w;
    logic [ROW_W-1:0]     bank_rows [NUM_BANKS];

    assign run = (pwr == PWR_RUN);

    sdram_cmd_capture #(
        .ROW_W (ROW_W),
        .BA_W  (BA_W),
        .AP_BIT(AP_BIT)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr),
        .run   (run),
        .strobe(st),
        .ba_q  (ba_q),
        .addr_q(addr_q),
        .cke_q (cke_q)
    );

    // Legality of the shown command against current bank state
    always_comb begin
        sel        = NUM_BANKS'(1) << ba_q;
        tgt_active = bank_active[ba_q];
        tgt_ap     = ap_pending[ba_q];
        any_active = |bank_active;
        is_rw      = st.rd || st.wr;
        is_hk      = st.refr || st.mrs;
        act_ok     = st.act && !tgt_active;
        rw_ok      = is_rw && tgt_active && !tgt_ap;
        hk_ok      = is_hk && !any_active;
        illegal_cmd = (st.act && tgt_active) || (is_rw && !rw_ok) || (is_hk && any_active);
    end

    assign beats_w = CNT_W'(burst_beats(mode_word[2:0], COL_W));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_unit #(
            .ROW_W(ROW_W),
            .CNT_W(CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .do_act  (act_ok && sel[b]),
            .row_in  (addr_q),
            .do_rw_ap(rw_ok && addr_q[AP_BIT] && sel[b]),
            .beats   (beats_w),
            .do_close((st.pre && sel[b]) || st.prea),
            .active  (bank_active[b]),
            .row     (bank_rows[b]),
            .ap_pend (ap_pending[b])
        );
        assign open_rows[b*ROW_W +: ROW_W] = bank_rows[b];
    end

    sdram_burst_track #(
        .BA_W (BA_W),
        .CNT_W(CNT_W)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rw_ok),
        .start_bank(ba_q),
        .beats     (beats_w),
        .stop      (st.bst),
        .pre_one   (st.pre),
        .pre_bank  (ba_q),
        .pre_all   (st.prea),
        .busy      (burst_busy)
    );

    sdram_power_ctl u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_q     (cke_q),
        .sr_req    (st.refr && hk_ok),
        .any_active(any_active),
        .state     (pwr)
    );

    // Mode word update on a legal mode register set
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_word <= '0;
        else if (st.mrs && hk_ok) mode_word <= addr_q;
    end

    assign cmd_nop     = st.nop;
    assign cmd_act     = st.act;
    assign cmd_rd      = st.rd;
    assign cmd_wr      = st.wr;
    assign cmd_pre     = st.pre;
    assign cmd_prea    = st.prea;
    assign cmd_ref     = st.refr;
    assign cmd_bst     = st.bst;
    assign cmd_mrs     = st.mrs;
    assign cmd_bank    = ba_q;
    assign cmd_col     = addr_q[COL_W-1:0];
    assign cmd_autopre = addr_q[AP_BIT];
    assign pwr_state   = pwr;

    // R2
    deselect_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> cmd_nop);

    // R11
    lowpower_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0) |-> cmd_nop);

    // R5
    illegal_act_keeps_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_cmd && cmd_act && !ap_pending[ba_q]) |=>
            (bank_active[$past(ba_q)] && bank_rows[$past(ba_q)] == $past(bank_rows[ba_q])));

endmodule

// File: tb/sdram_cmd_front_tb.sv
// Bench: behavioural reference model compared against the design every cycle.
module sdram_cmd_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;

    logic        cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref, cmd_bst, cmd_mrs;
    logic [1:0]  cmd_bank;
    logic [7:0]  cmd_col;
    logic        cmd_autopre, illegal_cmd, burst_busy;
    logic [3:0]  bank_active, ap_pending;
    logic [47:0] open_rows;
    logic [1:0]  pwr_state;
    logic [11:0] mode_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_nop(cmd_nop), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_pre(cmd_pre), .cmd_prea(cmd_prea), .cmd_ref(cmd_ref), .cmd_bst(cmd_bst),
        .cmd_mrs(cmd_mrs), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_autopre(cmd_autopre), .illegal_cmd(illegal_cmd),
        .bank_active(bank_active), .ap_pending(ap_pending), .open_rows(open_rows),
        .burst_busy(burst_busy), .pwr_state(pwr_state), .mode_word(mode_word)
    );

    // ---------------- reference model ----------------
    logic m_cs, m_ras, m_cas, m_we, m_cke;
    int   m_ba, m_addr;
    bit   m_act [4];
    int   m_row [4];
    bit   m_ap  [4];
    int   m_apc [4];
    int   m_bcnt, m_bbank, m_mode, m_pwr;
    int   k;
    bit   act_ok, rw_ok, hk_ok, ill, anyact;

    function automatic int beats(input int code);
        case (code & 7)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 256;
            default: return 1;
        endcase
    endfunction

    task automatic model_reset();
        m_cs = 1; m_ras = 1; m_cas = 1; m_we = 1; m_cke = 1; m_ba = 0; m_addr = 0;
        for (int b = 0; b < 4; b++) begin
            m_act[b] = 0; m_row[b] = 0; m_ap[b] = 0; m_apc[b] = 0;
        end
        m_bcnt = 0; m_bbank = 0; m_mode = 0; m_pwr = 0;
    endtask

    // Classify the held command: 0 nop 1 act 2 rd 3 wr 4 pre 5 prea 6 ref 7 bst 8 mrs
    task automatic eval_cmd();
        bit ta, tap;
        if (m_pwr != 0 || m_cs) k = 0;
        else case ({m_ras, m_cas, m_we})
            3'b111: k = 0;
            3'b011: k = 1;
            3'b101: k = 2;
            3'b100: k = 3;
            3'b010: k = ((m_addr >> 10) & 1) ? 5 : 4;
            3'b001: k = 6;
            3'b110: k = 7;
            default: k = 8;
        endcase
        anyact = m_act[0] | m_act[1] | m_act[2] | m_act[3];
        ta  = m_act[m_ba];
        tap = m_ap[m_ba];
        act_ok = (k == 1) && !ta;
        rw_ok  = (k == 2 || k == 3) && ta && !tap;
        hk_ok  = (k == 6 || k == 8) && !anyact;
        ill    = ((k == 1) && ta) || ((k == 2 || k == 3) && !(ta && !tap)) ||
                 ((k == 6 || k == 8) && anyact);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int bl;
            eval_cmd();
            bl = beats(m_mode);
            for (int b = 0; b < 4; b++) begin
                if ((k == 4 && b == m_ba) || k == 5) begin
                    m_act[b] = 0; m_row[b] = 0; m_ap[b] = 0; m_apc[b] = 0;
                end else if (act_ok && b == m_ba) begin
                    m_act[b] = 1; m_row[b] = m_addr;
                end else if (rw_ok && b == m_ba && ((m_addr >> 10) & 1)) begin
                    m_ap[b] = 1; m_apc[b] = bl;
                end else if (m_ap[b] && m_apc[b] == 1) begin
                    m_act[b] = 0; m_row[b] = 0; m_ap[b] = 0; m_apc[b] = 0;
                end else if (m_ap[b]) begin
                    m_apc[b]--;
                end
            end
            if (k == 7 || k == 5 || (k == 4 && m_ba == m_bbank)) m_bcnt = 0;
            else if (rw_ok) begin m_bcnt = bl; m_bbank = m_ba; end
            else if (m_bcnt > 0) m_bcnt--;
            if (k == 8 && hk_ok) m_mode = m_addr;
            if (m_cke) m_pwr = 0;
            else if (m_pwr == 0) m_pwr = (k == 6 && hk_ok) ? 2 : (anyact ? 3 : 1);
            m_cs = cs_n; m_ras = ras_n; m_cas = cas_n; m_we = we_n;
            m_ba = ba; m_addr = addr; m_cke = cke;
            started = 1;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act_v, input logic [63:0] exp_v);
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act_v, exp_v, $time);
        end
    endtask

    // Compare every output away from the active edge
    always @(negedge clk) begin
        if (started && rst_n) begin
            logic [8:0]  e_str;
            logic [3:0]  e_act, e_ap;
            logic [47:0] e_rows;
            string stag;
            eval_cmd();
            e_str = 9'b1 << (8 - k);
            for (int b = 0; b < 4; b++) begin
                e_act[b] = m_act[b];
                e_ap[b]  = m_ap[b];
                e_rows[b*12 +: 12] = 12'(m_row[b]);
            end
            if (m_cs) stag = "R2";
            else if (m_pwr != 0) stag = "R11";
            else stag = "R1,R3";
            chk(stag, "strobes", {cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea,
                                  cmd_ref, cmd_bst, cmd_mrs}, e_str);
            chk("R3", "cmd_bank", cmd_bank, m_ba[1:0]);
            chk("R3", "cmd_col", cmd_col, m_addr[7:0]);
            chk("R3", "cmd_autopre", cmd_autopre, m_addr[10]);
            chk("R5", "illegal_cmd", illegal_cmd, ill);
            chk("R4", "bank_active", bank_active, e_act);
            chk("R6", "open_rows", open_rows, e_rows);
            chk("R7", "ap_pending", ap_pending, e_ap);
            chk("R9", "burst_busy", burst_busy, m_bcnt != 0);
            chk("R10", "pwr_state", pwr_state, m_pwr[1:0]);
            chk("R8", "mode_word", mode_word, m_mode[11:0]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic c, input logic r, input logic a,
                         input logic w, input int b, input int ad, input logic ck);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = 2'(b); addr = 12'(ad); cke = ck;
    endtask

    task automatic nop(input int n = 1);
        for (int i = 0; i < n; i++) drive(0, 1, 1, 1, 0, 0, 1);
    endtask
    task automatic act(input int b, input int row); drive(0, 0, 1, 1, b, row, 1); endtask
    task automatic rd(input int b, input int col, input bit ap);
        drive(0, 1, 0, 1, b, col | (ap << 10), 1);
    endtask
    task automatic wr(input int b, input int col, input bit ap);
        drive(0, 1, 0, 0, b, col | (ap << 10), 1);
    endtask
    task automatic pre(input int b); drive(0, 0, 1, 0, b, 0, 1); endtask
    task automatic prea(); drive(0, 0, 1, 0, 0, 12'h400, 1); endtask
    task automatic refr(input logic ck); drive(0, 0, 0, 1, 0, 0, ck); endtask
    task automatic bst(); drive(0, 1, 1, 0, 0, 0, 1); endtask
    task automatic mrs(input int v); drive(0, 0, 0, 0, 0, v, 1); endtask

    // R12: explicit reset-state check at the ports
    task automatic reset_check();
        @(negedge clk);
        chk("R12", "reset nop", cmd_nop, 1);
        chk("R12", "reset illegal", illegal_cmd, 0);
        chk("R12", "reset active", bank_active, 0);
        chk("R12", "reset rows", open_rows, 0);
        chk("R12", "reset ap", ap_pending, 0);
        chk("R12", "reset busy", burst_busy, 0);
        chk("R12", "reset pwr", pwr_state, 0);
        chk("R12", "reset mode", mode_word, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        nop(3);
        // R2: deselected ACTIVE code has no effect
        drive(1, 0, 1, 1, 1, 12'h555, 1);
        nop(2);
        // R8: burst length 8
        mrs(12'h033);
        nop(2);
        // R4 / R5: open two banks, then a conflicting ACTIVE
        act(0, 12'hABC);
        act(1, 12'h123);
        act(0, 12'h0F0);
        nop(1);
        // R9: read then stop mid-burst
        rd(0, 5, 0);
        nop(3);
        bst();
        nop(2);
        // R7: write with auto precharge, then access while pending
        wr(1, 9, 1);
        nop(2);
        rd(1, 3, 0);
        act(1, 12'h777);
        nop(8);
        // R5: read to idle bank, refresh with bank open
        rd(2, 1, 0);
        refr(1);
        pre(0);
        pre(2);
        refr(1);
        nop(1);
        // R9 / R6: burst length 2, precharge ends the burst
        mrs(12'h001);
        act(3, 12'hFFF);
        mrs(12'h002);
        rd(3, 7, 0);
        pre(3);
        nop(2);
        // R6: precharge-all with several banks open and a pending auto precharge
        mrs(12'h003);
        act(0, 12'h011);
        act(2, 12'h022);
        rd(2, 4, 1);
        nop(2);
        prea();
        nop(2);
        // R10 / R11: self refresh entry, masked commands, exit
        refr(0);
        drive(0, 0, 1, 1, 0, 12'h100, 0);
        drive(0, 1, 0, 1, 0, 0, 0);
        drive(1, 1, 1, 1, 0, 0, 0);
        drive(1, 1, 1, 1, 0, 0, 1);
        nop(3);
        // R10: precharge power-down
        drive(0, 1, 1, 1, 0, 0, 0);
        drive(0, 1, 1, 1, 0, 0, 0);
        nop(3);
        // R10: active power-down with auto precharge expiring inside it
        act(2, 12'h2A2);
        wr(2, 0, 1);
        drive(0, 1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 12; i++) drive(0, 1, 1, 1, 0, 0, 0);
        nop(3);
        // R7 / R8: full-page burst with auto precharge
        mrs(12'h007);
        act(1, 12'h345);
        rd(1, 0, 1);
        nop(260);
        // R12: reset in the middle of activity
        mrs(12'h002);
        act(0, 12'h101);
        rd(0, 2, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        nop(2);
        // Mixed pseudo-random phase
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 15);
            int b   = $urandom_range(0, 3);
            int ad  = $urandom_range(0, 4095);
            logic ck = ($urandom_range(0, 19) != 0);
            if (sel == 8) ad = ad & 12'h403;
            case (sel)
                0, 1:   drive(0, 0, 1, 1, b, ad, ck);
                2, 3:   drive(0, 1, 0, 1, b, ad, ck);
                4:      drive(0, 1, 0, 0, b, ad, ck);
                5:      drive(0, 0, 1, 0, b, ad, ck);
                6:      drive(0, 0, 0, 1, b, ad, ck);
                7:      drive(0, 1, 1, 0, b, ad, ck);
                8:      drive(0, 0, 0, 0, b, ad, ck);
                9:      drive(1, 0, 1, 1, b, ad, ck);
                default: drive(0, 1, 1, 1, b, ad, ck);
            endcase
        end
        nop(4);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule